// File: doc/BRIEF.md
# Display Timing Parameter Register File

This block is the programming port of a raster display controller. A host writes the controller's timing parameters over an AXI-Lite write channel. These are the horizontal and vertical start, visible width, sync width and total count, plus the sync polarities, pixel format, line pitch and frame base address. The block holds them and drives them as steady outputs in the pixel clock domain. It has no read channel, and every write completes with an OKAY response.

Timing writes first land in a staging bank, and the pixel-side outputs do not move. A write of the commit bit copies the whole staged set into a committed bank. One toggle carries the news through a synchronizer into the pixel domain, which then loads every timing output on the same pixel clock edge. The frame base address skips the commit step. A new value crosses on its own toggle and is held pending. It reaches the output only on the next frame-start pulse from the timing generator, so a frame is never drawn from two buffers.

The address and data channels are independent. They may arrive in the same cycle or in either order, and a write that is waiting for its response blocks the next one.

Top module: `disp_timing_regs`

## Requirements
- R1: After reset the outputs are horizontal start 15, width 640, sync 96, total 799; vertical start 9, height 480, sync 2, total 524; format 0; both polarity bits 0; pitch 5; frame base 0.
- R2: A write completes whether the address and data handshakes happen in the same cycle, address first or data first. bvalid rises in the cycle after the second handshake, with bresp = 2'b00 (OKAY).
- R3: bvalid stays high until bready is sampled high, and it is low in the cycle after that handshake.
- R4: While a response is pending, awready and wready are both low. While one channel waits for the other, the ready of the channel already taken is low.
- R5: The register index is awaddr[11:2]: 0 control, 1 horizontal start, 2 horizontal width, 3 horizontal sync, 4 horizontal total, 5 vertical start, 6 vertical height, 7 vertical sync, 8 vertical total, 9 format (2 bits), 10 polarity (bit 0 hsync, bit 1 vsync), 11 pitch (13 bits), 12 frame base (32 bits). Timing fields are 12 bits. Data bits above a field's width are discarded.
- R6: Byte lane n (wdata[8n+7:8n]) of a register changes only when wstrb[n] is 1.
- R7: Writes to indices 1 to 11 do not change any output until a commit. A commit is a write to index 0 with wstrb[0] = 1 and wdata[0] = 1. Any other write to index 0 commits nothing.
- R8: After a commit, all timing, format, polarity and pitch outputs change on one pixel clock edge, within 12 pixel clock cycles.
- R9: A frame base write needs no commit and changes cfg_base only at the first frame_start pulse after the value reaches the pixel domain. Without a pulse cfg_base holds.
- R10: Writes to indices 13 and above change nothing and still complete with OKAY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset, bus domain |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| awaddr | input | 12 | Write byte address |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Byte strobes |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| bresp | output | 2 | Write response code, always OKAY |
| pix_clk | input | 1 | Pixel clock |
| pix_rst | input | 1 | Synchronous active-high reset, pixel domain |
| frame_start | input | 1 | One-cycle pulse at the frame boundary, pixel domain |
| cfg_h_start | output | 12 | Committed horizontal display start |
| cfg_h_width | output | 12 | Committed horizontal visible width |
| cfg_h_sync | output | 12 | Committed horizontal sync width |
| cfg_h_total | output | 12 | Committed horizontal total |
| cfg_v_start | output | 12 | Committed vertical display start |
| cfg_v_height | output | 12 | Committed vertical visible height |
| cfg_v_sync | output | 12 | Committed vertical sync width |
| cfg_v_total | output | 12 | Committed vertical total |
| cfg_fmt | output | 2 | Committed pixel format |
| cfg_hs_pol | output | 1 | Committed hsync polarity |
| cfg_vs_pol | output | 1 | Committed vsync polarity |
| cfg_pitch | output | 13 | Committed line pitch |
| cfg_base | output | 32 | Frame base address in use |

## Verification
The handshake properties assume a master that follows AXI-Lite. It holds awvalid or wvalid until the matching ready is seen and never raises valid for a second write before the response is taken. The bench's write task raises each valid at a falling edge, lowers it one cycle after the handshake, and delays bready by a varying number of cycles. The frame base property assumes frame_start is a pulse in the pixel domain. The bench drives it only between falling pixel edges, well after a base write has had time to cross.

// File: rtl/dtr_pkg.sv
package dtr_pkg;
  localparam int BUS_W = 32;
  localparam int NREG  = 13;

  localparam int R_CTRL   = 0;
  localparam int R_HSTART = 1;
  localparam int R_HWID   = 2;
  localparam int R_HSYNC  = 3;
  localparam int R_HTOT   = 4;
  localparam int R_VSTART = 5;
  localparam int R_VHGT   = 6;
  localparam int R_VSYNC  = 7;
  localparam int R_VTOT   = 8;
  localparam int R_FMT    = 9;
  localparam int R_POL    = 10;
  localparam int R_PITCH  = 11;
  localparam int R_BASE   = 12;

  typedef enum logic [1:0] {
    WS_IDLE      = 2'd0,
    WS_WAIT_DATA = 2'd1,
    WS_WAIT_ADDR = 2'd2,
    WS_RESP      = 2'd3
  } wr_state_t;

  // width of the storage field behind each register index
  function automatic int field_w(int idx, int cnt_w, int fmt_w, int pitch_w);
    case (idx)
      R_CTRL:  return 1;
      R_FMT:   return fmt_w;
      R_POL:   return 2;
      R_PITCH: return pitch_w;
      R_BASE:  return BUS_W;
      default: return cnt_w;
    endcase
  endfunction

  function automatic logic [BUS_W-1:0] field_mask(int idx, int cnt_w, int fmt_w, int pitch_w);
    int w;
    w = field_w(idx, cnt_w, fmt_w, pitch_w);
    if (w >= BUS_W) return '1;
    return (BUS_W'(1) << w) - BUS_W'(1);
  endfunction

  // power-up mode: 640x480 raster
  function automatic logic [BUS_W-1:0] reset_val(int idx);
    case (idx)
      R_HSTART: return BUS_W'(15);
      R_HWID:   return BUS_W'(640);
      R_HSYNC:  return BUS_W'(96);
      R_HTOT:   return BUS_W'(799);
      R_VSTART: return BUS_W'(9);
      R_VHGT:   return BUS_W'(480);
      R_VSYNC:  return BUS_W'(2);
      R_VTOT:   return BUS_W'(524);
      R_PITCH:  return BUS_W'(5);
      default:  return '0;
    endcase
  endfunction
endpackage

// File: rtl/dtr_axil_wr.sv
module dtr_axil_wr
  import dtr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int STRB_W = BUS_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              awvalid,
  output logic              awready,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              wvalid,
  output logic              wready,
  input  logic [BUS_W-1:0]  wdata,
  input  logic [STRB_W-1:0] wstrb,
  output logic              bvalid,
  input  logic              bready,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BUS_W-1:0]  wr_data,
  output logic [STRB_W-1:0] wr_strb
);
  wr_state_t st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= WS_IDLE;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      wr_strb <= '0;
    end else begin
      wr_en <= 1'b0;
      case (st)
        WS_IDLE: begin
          if (awvalid && wvalid) begin
            wr_addr <= awaddr;
            wr_data <= wdata;
            wr_strb <= wstrb;
            wr_en   <= 1'b1;
            st      <= WS_RESP;
          end else if (awvalid) begin
            wr_addr <= awaddr;
            st      <= WS_WAIT_DATA;
          end else if (wvalid) begin
            wr_data <= wdata;
            wr_strb <= wstrb;
            st      <= WS_WAIT_ADDR;
          end
        end
        WS_WAIT_DATA: begin
          if (wvalid) begin
            wr_data <= wdata;
            wr_strb <= wstrb;
            wr_en   <= 1'b1;
            st      <= WS_RESP;
          end
        end
        WS_WAIT_ADDR: begin
          if (awvalid) begin
            wr_addr <= awaddr;
            wr_en   <= 1'b1;
            st      <= WS_RESP;
          end
        end
        default: begin
          if (bready) st <= WS_IDLE;
        end
      endcase
    end
  end

  assign awready = (st == WS_IDLE) || (st == WS_WAIT_ADDR);
  assign wready  = (st == WS_IDLE) || (st == WS_WAIT_DATA);
  assign bvalid  = (st == WS_RESP);
endmodule

// File: rtl/dtr_bank.sv
module dtr_bank
  import dtr_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int CNT_W   = 12,
  parameter int FMT_W   = 2,
  parameter int PITCH_W = 13,
  parameter int STRB_W  = BUS_W / 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [BUS_W-1:0]           wr_data,
  input  logic [STRB_W-1:0]          wr_strb,
  output logic [NREG-1:0][BUS_W-1:0] committed,
  output logic                       load_tgl,
  output logic                       base_tgl
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]          idx;
  logic [BUS_W-1:0]          lane_mask;
  logic [NREG-1:0][BUS_W-1:0] staged;
  logic                      commit;

  assign idx = wr_addr[ADDR_W-1:2];

  always_comb begin
    for (int b = 0; b < STRB_W; b++) lane_mask[8*b +: 8] = {8{wr_strb[b]}};
  end

  assign commit = wr_en && (idx == IDX_W'(R_CTRL)) && wr_strb[0] && wr_data[0];

  assign staged[R_CTRL]    = '0;
  assign committed[R_CTRL] = '0;

  generate
    for (genvar g = 1; g < NREG; g++) begin : g_reg
      localparam logic [BUS_W-1:0] FMASK = field_mask(g, CNT_W, FMT_W, PITCH_W);
      logic [BUS_W-1:0] wmask;
      assign wmask = lane_mask & FMASK;

      always_ff @(posedge clk) begin
        if (rst)
          staged[g] <= reset_val(g);
        else if (wr_en && idx == IDX_W'(g))
          staged[g] <= (staged[g] & ~wmask) | (wr_data & wmask);
      end

      if (g == R_BASE) begin : g_direct
        // the base bypasses the commit and crosses on its own toggle
        assign committed[g] = staged[g];
      end else begin : g_shadow
        always_ff @(posedge clk) begin
          if (rst)         committed[g] <= reset_val(g);
          else if (commit) committed[g] <= staged[g];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      load_tgl <= 1'b0;
      base_tgl <= 1'b0;
    end else begin
      if (commit) load_tgl <= ~load_tgl;
      if (wr_en && idx == IDX_W'(R_BASE)) base_tgl <= ~base_tgl;
    end
  end
endmodule

// File: rtl/dtr_sync.sv
module dtr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dtr_pix_apply.sv
module dtr_pix_apply
  import dtr_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int FMT_W       = 2,
  parameter int PITCH_W     = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       pix_clk,
  input  logic                       pix_rst,
  input  logic                       load_tgl,
  input  logic                       base_tgl,
  input  logic [NREG-1:0][BUS_W-1:0] committed,
  input  logic                       frame_start,
  output logic [CNT_W-1:0]           cfg_h_start,
  output logic [CNT_W-1:0]           cfg_h_width,
  output logic [CNT_W-1:0]           cfg_h_sync,
  output logic [CNT_W-1:0]           cfg_h_total,
  output logic [CNT_W-1:0]           cfg_v_start,
  output logic [CNT_W-1:0]           cfg_v_height,
  output logic [CNT_W-1:0]           cfg_v_sync,
  output logic [CNT_W-1:0]           cfg_v_total,
  output logic [FMT_W-1:0]           cfg_fmt,
  output logic                       cfg_hs_pol,
  output logic                       cfg_vs_pol,
  output logic [PITCH_W-1:0]         cfg_pitch,
  output logic [BUS_W-1:0]           cfg_base
);
  logic load_s, load_d, base_s, base_d;
  logic load_edge, base_edge;
  logic base_pend;
  logic [BUS_W-1:0] base_hold;

  dtr_sync #(.STAGES(SYNC_STAGES)) u_load_sync (
    .clk(pix_clk), .rst(pix_rst), .d(load_tgl), .q(load_s));
  dtr_sync #(.STAGES(SYNC_STAGES)) u_base_sync (
    .clk(pix_clk), .rst(pix_rst), .d(base_tgl), .q(base_s));

  assign load_edge = load_s ^ load_d;
  assign base_edge = base_s ^ base_d;

  always_ff @(posedge pix_clk) begin
    if (pix_rst) begin
      load_d       <= 1'b0;
      base_d       <= 1'b0;
      cfg_h_start  <= CNT_W'(reset_val(R_HSTART));
      cfg_h_width  <= CNT_W'(reset_val(R_HWID));
      cfg_h_sync   <= CNT_W'(reset_val(R_HSYNC));
      cfg_h_total  <= CNT_W'(reset_val(R_HTOT));
      cfg_v_start  <= CNT_W'(reset_val(R_VSTART));
      cfg_v_height <= CNT_W'(reset_val(R_VHGT));
      cfg_v_sync   <= CNT_W'(reset_val(R_VSYNC));
      cfg_v_total  <= CNT_W'(reset_val(R_VTOT));
      cfg_fmt      <= '0;
      cfg_hs_pol   <= 1'b0;
      cfg_vs_pol   <= 1'b0;
      cfg_pitch    <= PITCH_W'(reset_val(R_PITCH));
    end else begin
      load_d <= load_s;
      base_d <= base_s;
      if (load_edge) begin
        cfg_h_start  <= committed[R_HSTART][CNT_W-1:0];
        cfg_h_width  <= committed[R_HWID][CNT_W-1:0];
        cfg_h_sync   <= committed[R_HSYNC][CNT_W-1:0];
        cfg_h_total  <= committed[R_HTOT][CNT_W-1:0];
        cfg_v_start  <= committed[R_VSTART][CNT_W-1:0];
        cfg_v_height <= committed[R_VHGT][CNT_W-1:0];
        cfg_v_sync   <= committed[R_VSYNC][CNT_W-1:0];
        cfg_v_total  <= committed[R_VTOT][CNT_W-1:0];
        cfg_fmt      <= committed[R_FMT][FMT_W-1:0];
        cfg_hs_pol   <= committed[R_POL][0];
        cfg_vs_pol   <= committed[R_POL][1];
        cfg_pitch    <= committed[R_PITCH][PITCH_W-1:0];
      end
    end
  end

  // frame base: capture on arrival, apply at the frame boundary
  always_ff @(posedge pix_clk) begin
    if (pix_rst) begin
      base_pend <= 1'b0;
      base_hold <= '0;
      cfg_base  <= '0;
    end else begin
      if (frame_start && base_pend) cfg_base <= base_hold;
      if (base_edge) begin
        base_hold <= committed[R_BASE];
        base_pend <= 1'b1;
      end else if (frame_start) begin
        base_pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/disp_timing_regs.sv
module disp_timing_regs
  import dtr_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int CNT_W       = 12,
  parameter int FMT_W       = 2,
  parameter int PITCH_W     = 13,
  parameter int SYNC_STAGES = 2,
  localparam int STRB_W     = BUS_W / 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               awvalid,
  output logic               awready,
  input  logic [ADDR_W-1:0]  awaddr,
  input  logic               wvalid,
  output logic               wready,
  input  logic [BUS_W-1:0]   wdata,
  input  logic [STRB_W-1:0]  wstrb,
  output logic               bvalid,
  input  logic               bready,
  output logic [1:0]         bresp,
  input  logic               pix_clk,
  input  logic               pix_rst,
  input  logic               frame_start,
  output logic [CNT_W-1:0]   cfg_h_start,
  output logic [CNT_W-1:0]   cfg_h_width,
  output logic [CNT_W-1:0]   cfg_h_sync,
  output logic [CNT_W-1:0]   cfg_h_total,
  output logic [CNT_W-1:0]   cfg_v_start,
  output logic [CNT_W-1:0]   cfg_v_height,
  output logic [CNT_W-1:0]   cfg_v_sync,
  output logic [CNT_W-1:0]   cfg_v_total,
  output logic [FMT_W-1:0]   cfg_fmt,
  output logic               cfg_hs_pol,
  output logic               cfg_vs_pol,
  output logic [PITCH_W-1:0] cfg_pitch,
  output logic [BUS_W-1:0]   cfg_base
);
  logic                       wr_en;
  logic [ADDR_W-1:0]          wr_addr;
  logic [BUS_W-1:0]           wr_data;
  logic [STRB_W-1:0]          wr_strb;
  logic [NREG-1:0][BUS_W-1:0] committed;
  logic                       load_tgl, base_tgl;

  assign bresp = 2'b00;

  dtr_axil_wr #(.ADDR_W(ADDR_W), .STRB_W(STRB_W)) u_wr (
    .clk(clk), .rst(rst),
    .awvalid(awvalid), .awready(awready), .awaddr(awaddr),
    .wvalid(wvalid), .wready(wready), .wdata(wdata), .wstrb(wstrb),
    .bvalid(bvalid), .bready(bready),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb));

  dtr_bank #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .FMT_W(FMT_W),
             .PITCH_W(PITCH_W), .STRB_W(STRB_W)) u_bank (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
    .committed(committed), .load_tgl(load_tgl), .base_tgl(base_tgl));

  dtr_pix_apply #(.CNT_W(CNT_W), .FMT_W(FMT_W), .PITCH_W(PITCH_W),
                  .SYNC_STAGES(SYNC_STAGES)) u_pix (
    .pix_clk(pix_clk), .pix_rst(pix_rst),
    .load_tgl(load_tgl), .base_tgl(base_tgl), .committed(committed),
    .frame_start(frame_start),
    .cfg_h_start(cfg_h_start), .cfg_h_width(cfg_h_width),
    .cfg_h_sync(cfg_h_sync), .cfg_h_total(cfg_h_total),
    .cfg_v_start(cfg_v_start), .cfg_v_height(cfg_v_height),
    .cfg_v_sync(cfg_v_sync), .cfg_v_total(cfg_v_total),
    .cfg_fmt(cfg_fmt), .cfg_hs_pol(cfg_hs_pol), .cfg_vs_pol(cfg_vs_pol),
    .cfg_pitch(cfg_pitch), .cfg_base(cfg_base));
endmodule

// File: rtl/dtr_checker.sv
module dtr_checker #(
  parameter int BASE_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              awvalid,
  input logic              awready,
  input logic              wvalid,
  input logic              wready,
  input logic              bvalid,
  input logic              bready,
  input logic              pix_clk,
  input logic              pix_rst,
  input logic              frame_start,
  input logic [BASE_W-1:0] cfg_base
);
  assert_bvalid_after_hs_R2: assert property (@(posedge clk) disable iff (rst)
    (awvalid && awready && wvalid && wready) |=> bvalid);

  assert_resp_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (bvalid && !bready) |=> bvalid);

  assert_resp_drop_R3: assert property (@(posedge clk) disable iff (rst)
    (bvalid && bready) |=> !bvalid);

  assert_no_accept_R4: assert property (@(posedge clk) disable iff (rst)
    bvalid |-> (!awready && !wready));

  assert_base_hold_R9: assert property (@(posedge pix_clk) disable iff (pix_rst)
    !frame_start |=> $stable(cfg_base));
endmodule

bind disp_timing_regs dtr_checker #(.BASE_W(dtr_pkg::BUS_W)) u_chk (
  .clk(clk), .rst(rst), .awvalid(awvalid), .awready(awready),
  .wvalid(wvalid), .wready(wready), .bvalid(bvalid), .bready(bready),
  .pix_clk(pix_clk), .pix_rst(pix_rst), .frame_start(frame_start),
  .cfg_base(cfg_base));

// File: tb/tb_disp_timing_regs.sv
`timescale 1ns/1ps
module tb_disp_timing_regs;
  logic        clk = 1'b0, pix_clk = 1'b0;
  logic        rst = 1'b1, pix_rst = 1'b1;
  logic        awvalid = 1'b0, wvalid = 1'b0, bready = 1'b0, frame_start = 1'b0;
  logic [11:0] awaddr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  wstrb = '0;
  logic        awready, wready, bvalid;
  logic [1:0]  bresp;
  logic [11:0] cfg_h_start, cfg_h_width, cfg_h_sync, cfg_h_total;
  logic [11:0] cfg_v_start, cfg_v_height, cfg_v_sync, cfg_v_total;
  logic [1:0]  cfg_fmt;
  logic        cfg_hs_pol, cfg_vs_pol;
  logic [12:0] cfg_pitch;
  logic [31:0] cfg_base;

  int checks = 0, fails = 0;
  logic [31:0] stg [13];
  logic [31:0] act [13];
  logic [31:0] base_exp;

  always #2.5 clk = ~clk;
  always #3.5 pix_clk = ~pix_clk;

  disp_timing_regs dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] a, input logic [31:0] e);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, a, e);
    end
  endtask

  function automatic logic [31:0] fmask(int idx);
    case (idx)
      0: return 32'h1;
      9: return 32'h3;
      10: return 32'h3;
      11: return 32'h1FFF;
      12: return 32'hFFFF_FFFF;
      default: return 32'hFFF;
    endcase
  endfunction

  function automatic logic [31:0] out_of(int idx);
    case (idx)
      1: return 32'(cfg_h_start);  2: return 32'(cfg_h_width);
      3: return 32'(cfg_h_sync);   4: return 32'(cfg_h_total);
      5: return 32'(cfg_v_start);  6: return 32'(cfg_v_height);
      7: return 32'(cfg_v_sync);   8: return 32'(cfg_v_total);
      9: return 32'(cfg_fmt);      10: return {30'd0, cfg_vs_pol, cfg_hs_pol};
      11: return 32'(cfg_pitch);
      default: return cfg_base;
    endcase
  endfunction

  // model of a completed write (R5, R6, R7, R10)
  task automatic mdl(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s);
    int idx = int'(a >> 2);
    logic [31:0] m = 0;
    for (int b = 0; b < 4; b++) if (s[b]) m[8*b +: 8] = 8'hFF;
    if (idx >= 1 && idx <= 12) begin
      m = m & fmask(idx);
      stg[idx] = (stg[idx] & ~m) | (d & m);
    end else if (idx == 0 && s[0] && d[0]) begin
      for (int i = 1; i <= 11; i++) act[i] = stg[i];
    end
  endtask

  // order: 0 together, 1 address first, 2 data first
  task automatic axi_write(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s,
                           input int order, input int bdly);
    int t;
    @(negedge clk);
    if (order == 0) begin
      awaddr = a; wdata = d; wstrb = s; awvalid = 1; wvalid = 1;
      while (!(awready && wready)) @(negedge clk);
      @(negedge clk); awvalid = 0; wvalid = 0;
    end else if (order == 1) begin
      awaddr = a; awvalid = 1;
      while (!awready) @(negedge clk);
      @(negedge clk); awvalid = 0;
      repeat (2) @(negedge clk);
      chk(!awready && wready, "R4 addr taken, waiting data", {awready, wready}, 32'b01);
      wdata = d; wstrb = s; wvalid = 1;
      while (!wready) @(negedge clk);
      @(negedge clk); wvalid = 0;
    end else begin
      wdata = d; wstrb = s; wvalid = 1;
      while (!wready) @(negedge clk);
      @(negedge clk); wvalid = 0;
      repeat (2) @(negedge clk);
      chk(awready && !wready, "R4 data taken, waiting addr", {awready, wready}, 32'b10);
      awaddr = a; awvalid = 1;
      while (!awready) @(negedge clk);
      @(negedge clk); awvalid = 0;
    end
    chk(bvalid === 1'b1, "R2 bvalid after second handshake", bvalid, 1);
    chk(bresp == 2'b00, "R2 OKAY response", bresp, 0);
    t = 0;
    while (t < bdly) begin
      @(negedge clk); t++;
      chk(bvalid && !awready && !wready, "R3 R4 response held, channels closed",
          {bvalid, awready, wready}, 32'b100);
    end
    bready = 1;
    @(negedge clk); bready = 0;
    chk(bvalid == 1'b0, "R3 bvalid drops after bready", bvalid, 0);
    mdl(a, d, s);
  endtask

  task automatic check_outs(input string req);
    for (int i = 1; i <= 11; i++) chk(out_of(i) == act[i], req, out_of(i), act[i]);
  endtask

  task automatic pix_wait(input int n);
    repeat (n) @(negedge pix_clk);
  endtask

  task automatic frame_pulse;
    @(negedge pix_clk); frame_start = 1;
    @(negedge pix_clk); frame_start = 0;
    pix_wait(1);
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 13; i++) stg[i] = 0;
    stg[1] = 15; stg[2] = 640; stg[3] = 96; stg[4] = 799;
    stg[5] = 9;  stg[6] = 480; stg[7] = 2;  stg[8] = 524; stg[11] = 5;
    for (int i = 0; i < 13; i++) act[i] = stg[i];
    base_exp = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge pix_clk); pix_rst = 0;
    pix_wait(2);

    // R1 reset state
    check_outs("R1 reset value");
    chk(cfg_base == 0, "R1 reset base", cfg_base, 0);
    chk(awready && wready && !bvalid, "R1 idle handshake", {awready, wready, bvalid}, 32'b110);

    // R7 staged writes invisible; R8 commit lands on one edge
    axi_write(12'h008, 32'd100, 4'hF, 0, 0);
    axi_write(12'h020, 32'd300, 4'hF, 1, 2);
    pix_wait(12);
    check_outs("R7 staged write not visible");
    axi_write(12'h000, 32'hFFFF_FFFE, 4'hF, 2, 1);
    axi_write(12'h000, 32'h1, 4'hE, 0, 0);
    pix_wait(12);
    check_outs("R7 no commit without bit 0 under lane 0");
    axi_write(12'h000, 32'h1, 4'h1, 0, 0);
    for (int k = 0; k < 12; k++) begin
      @(negedge pix_clk);
      chk((cfg_h_width == 640 && cfg_v_total == 524) || (cfg_h_width == 100 && cfg_v_total == 300),
          "R8 fields move together", {cfg_h_width, 4'h0, cfg_v_total}, {12'd100, 4'h0, 12'd300});
    end
    check_outs("R8 committed set");

    // R5 R7 R8 sweep over every staged register, all three orders
    for (int i = 1; i <= 11; i++) begin
      logic [31:0] v = (32'h9E37_79B9 * (i + 3)) ^ (i << 4);
      axi_write(12'(i * 4), v, 4'hF, i % 3, i % 4);
    end
    pix_wait(12);
    check_outs("R7 sweep staged not visible");
    axi_write(12'h000, 32'h3, 4'hF, 1, 0);
    pix_wait(12);
    check_outs("R5 R8 sweep committed, bits above field cut");

    // R6 byte strobe sweep on pitch and vertical total
    for (int s = 0; s < 16; s++) begin
      axi_write(12'h02C, 32'h5A5A_5A5A ^ (s * 32'h0101_0101), 4'(s), s % 3, 0);
      axi_write(12'h020, 32'hC3C3_C3C3 + s * 32'h0102_0304, 4'(s), 0, 0);
      axi_write(12'h000, 32'h1, 4'h1, 0, 0);
      pix_wait(10);
      chk(cfg_pitch == act[11][12:0], "R6 pitch lane strobe", cfg_pitch, act[11]);
      chk(cfg_v_total == act[8][11:0], "R6 v_total lane strobe", cfg_v_total, act[8]);
    end

    // R10 unmapped offsets
    axi_write(12'h034, 32'hFFFF_FFFF, 4'hF, 0, 1);
    axi_write(12'hFFC, 32'hFFFF_FFFF, 4'hF, 2, 0);
    axi_write(12'h000, 32'h1, 4'h1, 0, 0);
    pix_wait(12);
    check_outs("R10 unmapped write ignored");

    // R9 frame base: strobe sweep, applied only at a frame pulse
    for (int s = 0; s < 16; s++) begin
      axi_write(12'h030, 32'h1357_9BDF + s * 32'h1111_1111, 4'(s), s % 3, 0);
      pix_wait(12);
      chk(cfg_base == base_exp, "R9 base held before frame pulse", cfg_base, base_exp);
      frame_pulse();
      base_exp = stg[12];
      chk(cfg_base == base_exp, "R9 R6 base applied at frame pulse", cfg_base, base_exp);
    end
    frame_pulse();
    chk(cfg_base == base_exp, "R9 no pending base, pulse keeps value", cfg_base, base_exp);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule